// File: doc/BRIEF.md
# Serial converter read sequencer

This block is the host side of a three-wire link to an 8-bit successive-approximation converter. A client asks for one sample by pulsing `req` together with a channel-select bit, a single-ended/differential flag and a divider setting. The sequencer lowers the chip select and derives the serial clock from the system clock. It then shifts out the start bit and the two-bit addressing word. While the address goes out, the converter's data line is ignored. The converter next returns a settle bit, the result with the most significant bit first, and a replay of the result with the least significant bit first. The sequencer collects all of these and compares the replay against the first copy.

The result is delivered with a one-cycle `rd_valid` pulse. A mismatch flag reports a replay that disagrees with the first copy. A framing flag reports a settle bit that was not zero. Chip select is then held low for one more serial period, returned high, and kept high for a further period before a new request is taken. A divider value that would put the serial clock outside its legal range is refused with a one-cycle `cfg_err` pulse, and no transaction starts.

The controller moves through four states. ST_IDLE waits for a request. ST_SHIFT runs the clock from the cs-fall transition (accept) through the last capture (done-shift). ST_TAIL holds chip select low for the trailing period (tail-end). ST_GAP enforces the idle time at chip-select high (gap-end) before it returns to ST_IDLE. A refused request stays in ST_IDLE.

Top module: `adc_host_reader`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `ready` is 1, and `rd_valid`, `rd_mismatch`, `rd_frame_err` and `cfg_err` are 0.
- R2: A request is accepted only if `req_half` lies between ceil(CLK_HZ/4e6) and CLK_HZ/20000 inclusive (13 to 2500 at the default 50 MHz). That range keeps each clock phase at 250 ns or more and the clock at 10 kHz or more. Any other value gives a one-cycle `cfg_err` one cycle after the request, and `cs_n` stays 1.
- R3: While `cs_n` is 0, every high and low phase of `sclk` lasts exactly `req_half` system clocks. The first phase is the low phase that starts when `cs_n` falls.
- R4: On the first three rising `sclk` edges, `di` carries 1 (the start bit), then the mode bit (1 single-ended, 0 differential), then `req_odd` (channel select or polarity). `di` changes only while `sclk` is low and is 0 on every later rising edge.
- R5: `do_in` sampled on the 4th rising edge (the settle bit) is not part of the result. The bits on rising edges 5 to 12 form `rd_data` with the most significant bit first.
- R6: The bits on rising edges 13 to 19 are compared with result bits 1 to 7 in that order. Any difference sets `rd_mismatch` together with `rd_valid`.
- R7: A 1 sampled as the settle bit sets `rd_frame_err` together with `rd_valid`. The result is still delivered.
- R8: `rd_valid` is a single-cycle pulse that rises 37×`req_half` system clocks after the accepting edge.
- R9: `cs_n` returns to 1 one serial period (2×`req_half` clocks) after the last capture, which is 39×`req_half` after the accepting edge. `sclk` is 0 whenever `cs_n` is 1.
- R10: `ready` returns 2×`req_half` clocks after `cs_n` rises. A request made while `ready` is 0 is ignored.
- R11: Each transaction produces exactly 19 rising `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request one conversion read |
| req_single | input | 1 | 1 single-ended, 0 differential |
| req_odd | input | 1 | Channel select (single-ended) or polarity (differential) |
| req_half | input | DIV_W | System clocks per serial-clock phase |
| ready | output | 1 | Idle and able to accept a request |
| cfg_err | output | 1 | Pulse: request refused, divider out of range |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| di | output | 1 | Serial data to the converter |
| do_in | input | 1 | Serial data from the converter |
| rd_valid | output | 1 | Pulse: result fields updated |
| rd_data | output | RES_W | Conversion result |
| rd_mismatch | output | 1 | Replay disagreed with the first copy |
| rd_frame_err | output | 1 | Settle bit was not zero |

## Verification
All outputs of a transaction are timed from the edge that accepts the request. `rd_valid` is due 37 phases later, `cs_n` rises after 39 phases, and `ready` returns after 41 phases, where one phase is `req_half` clocks. `cfg_err` is due one cycle after a refused request. The bench samples on falling system-clock edges, counts rising edges to take timestamps, and compares each interval with these exact figures rather than waiting for an event. Its converter model reacts to the serial-clock edges as the device would. The same timestamps give the length of every serial-clock phase.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } host_state_e;

    // start bit plus mode bit plus odd/sign bit
    localparam int ADDR_BITS = 3;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise_en,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output logic             tick_hi,
    output logic             tick_lo
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = run && (cnt == half - DIV_W'(1));
    assign tick_hi = tick && sclk;
    assign tick_lo = tick && !sclk;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + DIV_W'(1);
            if (tick_hi || (tick_lo && rise_en))
                sclk <= ~sclk;
        end
    end
endmodule

// File: rtl/adc_rx_check.sv
module adc_rx_check #(
    parameter int RES_W = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    output logic [RES_W-1:0] result,
    output logic             mis_now,
    output logic             frame_now
);
    localparam int SETTLE_IDX = adc_host_pkg::ADDR_BITS + 1;
    localparam int RES_LAST   = SETTLE_IDX + RES_W;
    localparam int REP_LAST   = RES_LAST + RES_W - 1;
    localparam int POS_W      = $clog2(RES_W);

    logic             in_res, in_rep, is_settle;
    logic             mis_q, frm_q;
    logic [POS_W-1:0] rep_pos;

    assign in_res    = (idx > IDX_W'(SETTLE_IDX)) && (idx <= IDX_W'(RES_LAST));
    assign in_rep    = (idx > IDX_W'(RES_LAST)) && (idx <= IDX_W'(REP_LAST));
    assign is_settle = (idx == IDX_W'(SETTLE_IDX));
    assign rep_pos   = POS_W'(idx - IDX_W'(RES_LAST));

    // replay edge k after the result maps onto result bit k
    assign mis_now   = mis_q | (sample && in_rep && (din != result[rep_pos]));
    assign frame_now = frm_q | (sample && is_settle && din);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            result <= '0;
            mis_q  <= 1'b0;
            frm_q  <= 1'b0;
        end else begin
            if (sample && in_res)
                result <= {result[RES_W-2:0], din};
            mis_q <= mis_now;
            frm_q <= frame_now;
        end
    end
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader #(
    parameter int CLK_HZ = 50_000_000,
    parameter int DIV_W  = 16,
    parameter int RES_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_single,
    input  logic             req_odd,
    input  logic [DIV_W-1:0] req_half,
    output logic             ready,
    output logic             cfg_err,
    output logic             cs_n,
    output logic             sclk,
    output logic             di,
    input  logic             do_in,
    output logic             rd_valid,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_mismatch,
    output logic             rd_frame_err
);
    import adc_host_pkg::*;

    // phase >= 250 ns and period <= 100 us
    localparam int MIN_HALF    = (CLK_HZ + 3_999_999) / 4_000_000;
    localparam int MAX_HALF    = CLK_HZ / 20_000;
    localparam int FRAME_RISES = ADDR_BITS + 2 * RES_W;
    localparam int CNT_W       = $clog2(FRAME_RISES + 1);

    host_state_e      state, nxt;
    logic [DIV_W-1:0] half_q;
    logic             single_q, odd_q;
    logic [CNT_W-1:0] rcnt;
    logic             gap_cnt;
    logic             tick_hi, tick_lo, rise, last_rise;
    logic             accept, bad_div;
    logic [RES_W-1:0] res_bits;
    logic             mis_now, frm_now;

    assign ready     = (state == ST_IDLE);
    assign accept    = req && ready;
    assign bad_div   = (req_half < DIV_W'(MIN_HALF)) || (req_half > DIV_W'(MAX_HALF));
    assign rise      = tick_lo && (state == ST_SHIFT);
    assign last_rise = rise && (rcnt == CNT_W'(FRAME_RISES - 1));

    adc_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state != ST_IDLE),
        .rise_en (state == ST_SHIFT),
        .half    (half_q),
        .sclk    (sclk),
        .tick_hi (tick_hi),
        .tick_lo (tick_lo)
    );

    adc_rx_check #(.RES_W(RES_W), .IDX_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_IDLE),
        .sample    (rise),
        .idx       (rcnt + CNT_W'(1)),
        .din       (do_in),
        .result    (res_bits),
        .mis_now   (mis_now),
        .frame_now (frm_now)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept && !bad_div)   nxt = ST_SHIFT;
            ST_SHIFT: if (last_rise)            nxt = ST_TAIL;
            ST_TAIL:  if (tick_lo)              nxt = ST_GAP;
            ST_GAP:   if (tick_lo && gap_cnt)   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n         <= 1'b1;
            di           <= 1'b0;
            cfg_err      <= 1'b0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            rd_mismatch  <= 1'b0;
            rd_frame_err <= 1'b0;
            rcnt         <= '0;
            gap_cnt      <= 1'b0;
            half_q       <= DIV_W'(MIN_HALF);
            single_q     <= 1'b0;
            odd_q        <= 1'b0;
        end else begin
            cfg_err  <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    rcnt    <= '0;
                    gap_cnt <= 1'b0;
                    if (accept) begin
                        if (bad_div) begin
                            cfg_err <= 1'b1;
                        end else begin
                            cs_n     <= 1'b0;
                            di       <= 1'b1;
                            half_q   <= req_half;
                            single_q <= req_single;
                            odd_q    <= req_odd;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (rise)
                        rcnt <= rcnt + CNT_W'(1);
                    if (tick_hi) begin
                        if (rcnt == CNT_W'(1))      di <= single_q;
                        else if (rcnt == CNT_W'(2)) di <= odd_q;
                        else                        di <= 1'b0;
                    end
                    if (last_rise) begin
                        rd_valid     <= 1'b1;
                        rd_data      <= res_bits;
                        rd_mismatch  <= mis_now;
                        rd_frame_err <= frm_now;
                    end
                end
                ST_TAIL: begin
                    if (tick_lo) cs_n <= 1'b1;
                end
                ST_GAP: begin
                    if (tick_lo) gap_cnt <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_host_reader_chk.sv
module adc_host_reader_chk #(
    parameter int DIV_W       = 16,
    parameter int FRAME_RISES = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             ready,
    input logic [DIV_W-1:0] req_half,
    input logic             cfg_err,
    input logic             cs_n,
    input logic             sclk,
    input logic             di,
    input logic             rd_valid
);
    logic [DIV_W-1:0] half_q;
    logic [DIV_W:0]   run;
    logic             sclk_q;
    logic [7:0]       rises;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            run    <= '0;
            sclk_q <= 1'b0;
            rises  <= '0;
        end else begin
            if (req && ready) half_q <= req_half;
            sclk_q <= sclk;
            if (cs_n)                run <= '0;
            else if (sclk != sclk_q) run <= (DIV_W+1)'(1);
            else                     run <= run + (DIV_W+1)'(1);
            if (cs_n)                rises <= '0;
            else if (sclk && !sclk_q) rises <= rises + 8'd1;
        end
    end

    assert_sclk_low_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_ready_implies_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cs_n);

    assert_refused_no_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cs_n);

    assert_valid_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_di_stable_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(sclk)) |-> $stable(di));

    assert_phase_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sclk != sclk_q)) |-> (run == {1'b0, half_q}));

    assert_rise_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rises == 8'(FRAME_RISES)));
endmodule

bind adc_host_reader adc_host_reader_chk #(
    .DIV_W       (DIV_W),
    .FRAME_RISES (FRAME_RISES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ready    (ready),
    .req_half (req_half),
    .cfg_err  (cfg_err),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .di       (di),
    .rd_valid (rd_valid)
);

// File: tb/sim_adc_host_reader.sv
module sim_adc_host_reader;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // half, single, odd, vin0, vin1, bad_settle, flip, exp_data, exp_mis, exp_frm
    localparam logic [45:0] VEC [NVEC] = '{
        {16'd13,   1'b1, 1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        {16'd14,   1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        {16'd13,   1'b0, 1'b0, 8'h90, 8'h10, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0},
        {16'd20,   1'b0, 1'b1, 8'h90, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {16'd13,   1'b0, 1'b1, 8'h05, 8'hFF, 1'b0, 1'b0, 8'hFA, 1'b0, 1'b0},
        {16'd13,   1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
        {16'd13,   1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {16'd13,   1'b1, 1'b0, 8'h81, 8'h00, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0},
        {16'd13,   1'b1, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b1},
        {16'd2500, 1'b0, 1'b0, 8'h40, 8'h3F, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_single = 1'b0, req_odd = 1'b0;
    logic [15:0] req_half = 16'd13;
    logic        ready, cfg_err, cs_n, sclk, di, do_in;
    logic        rd_valid, rd_mismatch, rd_frame_err;
    logic [7:0]  rd_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cur_half = 13;
    logic [7:0] vin0 = 0, vin1 = 0;
    bit bad_settle = 0, flip = 0;
    // monitor and converter model state
    bit prev_cs = 1, prev_sclk = 0;
    int t_csl = 0, t_csh = 0, t_tog = 0, t_v = 0, nr = 0, nf = 0;
    int bad_phase = 0, di_late = 0, nvalid = 0;
    bit st_bit = 0, md_bit = 0, od_bit = 0;
    logic [7:0] mres = 0, cap_data = 0;
    bit cap_mis = 0, cap_frm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_host_reader u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_single(req_single), .req_odd(req_odd),
        .req_half(req_half), .ready(ready), .cfg_err(cfg_err), .cs_n(cs_n), .sclk(sclk),
        .di(di), .do_in(do_in), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_mismatch(rd_mismatch), .rd_frame_err(rd_frame_err)
    );

    function automatic logic [7:0] convert(bit sgl, bit odd, logic [7:0] a, logic [7:0] b);
        if (sgl) return odd ? b : a;
        if (!odd) return (a > b) ? a - b : 8'h00;
        return (b > a) ? b - a : 8'h00;
    endfunction

    // converter model and timestamps, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            do_in = 1'b0;
        end else begin
            if (prev_cs && !cs_n) begin
                t_csl = cyc; t_tog = cyc; nr = 0; nf = 0;
                bad_phase = 0; di_late = 0; do_in = 1'b0;
            end
            if (!cs_n && (sclk != prev_sclk)) begin
                if (cyc - t_tog != cur_half) bad_phase++;
                t_tog = cyc;
            end
            if (!cs_n && sclk && !prev_sclk) begin
                nr++;
                if (nr == 1) st_bit = di;
                else if (nr == 2) md_bit = di;
                else if (nr == 3) begin
                    od_bit = di;
                    mres = convert(md_bit, od_bit, vin0, vin1);
                end else if (di) di_late++;
            end
            if (!cs_n && !sclk && prev_sclk) begin
                nf++;
                if (nf == 3) do_in = bad_settle;
                else if (nf >= 4 && nf <= 11) do_in = mres[11-nf];
                else if (nf >= 12 && nf <= 18) do_in = mres[nf-11] ^ (flip && nf == 15);
                else do_in = 1'b0;
            end
            if (!prev_cs && cs_n) begin
                t_csh = cyc; do_in = 1'b0;
            end
            if (rd_valid) begin
                t_v = cyc; nvalid++;
                cap_data = rd_data; cap_mis = rd_mismatch; cap_frm = rd_frame_err;
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_read(input int h, input bit sgl, input bit odd, input logic [7:0] a,
                            input logic [7:0] b, input bit bs, input bit fl, input bit poke,
                            input logic [7:0] e_data, input bit e_mis, input bit e_frm);
        int v0, t_rdy;
        cur_half = h; vin0 = a; vin1 = b; bad_settle = bs; flip = fl;
        v0 = nvalid;
        @(negedge clk);
        req = 1'b1; req_half = 16'(h); req_single = sgl; req_odd = odd;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            repeat (100) @(negedge clk);
            req = 1'b1; req_odd = ~odd; req_single = ~sgl;
            @(negedge clk);
            req = 1'b0;
        end
        while (!ready) @(negedge clk);
        t_rdy = cyc;
        check(nvalid - v0 == 1, "R8", "valid pulses", nvalid - v0, 1);
        check(t_v - t_csl == 37*h, "R8", "valid delay", t_v - t_csl, 37*h);
        check(cap_data == e_data, "R5", "data", int'(cap_data), int'(e_data));
        check(cap_mis == e_mis, "R6", "mismatch", int'(cap_mis), int'(e_mis));
        check(cap_frm == e_frm, "R7", "frame err", int'(cap_frm), int'(e_frm));
        check(t_csh - t_csl == 39*h, "R9", "cs high delay", t_csh - t_csl, 39*h);
        check(t_rdy - t_csh == 2*h, "R10", "ready delay", t_rdy - t_csh, 2*h);
        check(bad_phase == 0, "R3", "bad phases", bad_phase, 0);
        check(nr == 19, "R11", "rising edges", nr, 19);
        check(st_bit == 1'b1, "R4", "start bit", int'(st_bit), 1);
        check(md_bit == sgl, "R4", "mode bit", int'(md_bit), int'(sgl));
        check(od_bit == odd, "R4", "odd bit", int'(od_bit), int'(odd));
        check(di_late == 0, "R4", "di high after word", di_late, 0);
    endtask

    task automatic refuse(input int h);
        @(negedge clk);
        req = 1'b1; req_half = 16'(h); req_single = 1'b1; req_odd = 1'b0;
        @(negedge clk);
        req = 1'b0;
        check(cfg_err == 1'b1, "R2", "cfg_err pulse", int'(cfg_err), 1);
        check(cs_n == 1'b1, "R2", "cs_n on refusal", int'(cs_n), 1);
        @(negedge clk);
        check(cfg_err == 1'b0, "R2", "cfg_err cleared", int'(cfg_err), 0);
        repeat (20) @(negedge clk);
        check(cs_n == 1'b1 && ready == 1'b1, "R2", "still idle", int'(cs_n & ready), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1", "pins in reset", int'({cs_n, sclk}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R1", "cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R1", "sclk", int'(sclk), 0);
        check(ready == 1'b1, "R1", "ready", int'(ready), 1);
        check({rd_valid, rd_mismatch, rd_frame_err, cfg_err} == 4'b0, "R1", "flags",
              int'({rd_valid, rd_mismatch, rd_frame_err, cfg_err}), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [45:0] v;
            v = VEC[i];
            run_read(int'(v[45:30]), v[29], v[28], v[27:20], v[19:12], v[11], v[10], 1'b0,
                     v[9:2], v[1], v[0]);
        end

        // divider limits just outside the range
        refuse(12);
        refuse(2501);

        // request while busy is ignored (R10)
        run_read(13, 1'b1, 1'b0, 8'h6C, 8'h11, 1'b0, 1'b0, 1'b1, 8'h6C, 1'b0, 1'b0);
        begin
            int low_seen;
            low_seen = 0;
            repeat (3*13) begin
                @(negedge clk);
                if (!cs_n) low_seen++;
            end
            check(low_seen == 0, "R10", "no second frame", low_seen, 0);
        end
        report();
    end
endmodule